// File: doc/BRIEF.md
# Streaming Window into a Word-Addressed Transfer Buffer

This block sits between a host register interface and a small shared transfer buffer. By default the buffer is 512 bytes, held as 128 words of 32 bits. The host does not address the buffer directly. It programs a control register with a fill/drain direction, an auto-advance enable and a starting word address. After that it moves data through a single data register, one full word per access. When auto-advance is on, each access that moves data steps the word pointer on by one. The pointer wraps from the last word back to the first.

A serial engine shares the same storage through a byte-wide port. That port reads and writes single bytes, and bytes are packed little-endian inside each word. A transfer whose length is not a multiple of four still ends with a full host word, and only its low-order bytes carry data. If the host and the engine both reach the buffer in the same cycle, the host access goes ahead and the engine write is dropped.

Top module: `bufwin_top`

## Requirements
- R1: After reset, a control read returns 0 (direction drain, auto-advance off, pointer 0) and hst_rdata is 0.
- R2: A control write loads the direction from bit 31 (1 = host fills the buffer), auto-advance from bit 30 and the word pointer from the low address bits. A later control read returns {dir, adv, 22'b0, pointer}, with address bits above the pointer width reading 0.
- R3: With direction 0, a data-register read returns the word at the pointer on hst_rdata from the cycle after the access. If auto-advance is 1 the pointer steps by one; if it is 0 the pointer stays put.
- R4: With direction 1, a data-register write stores all 32 bits at the pointer and steps the pointer when auto-advance is 1.
- R5: The pointer steps from WORDS-1 to 0.
- R6: A data-register write while the direction is 0 leaves the buffer and the pointer unchanged.
- R7: A data-register read while the direction is 1 returns the current word and does not move the pointer.
- R8: Engine byte address b maps to word b/4, bits 8*(b%4)+7 : 8*(b%4).
- R9: An engine byte write changes only the addressed byte of its word.
- R10: In a cycle with a host data-register access, any engine write is discarded, so the host data wins.
- R11: An engine byte read presents the byte on eng_rdata from the cycle after the request, and the value is the byte held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host register access this cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_dsel | input | 1 | 1 = data register, 0 = control register |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| eng_en | input | 1 | Engine byte access this cycle |
| eng_we | input | 1 | 1 = engine byte write |
| eng_addr | input | BADDR_W (9) | Engine byte address |
| eng_wdata | input | 8 | Engine write byte |
| eng_rdata | output | 8 | Registered engine read byte |

## Verification
The bench builds the block with WORDS set to 16, which gives a 4-bit pointer and a 64-byte buffer. That size lets the pointer wrap several times within one streamed transfer. It also lets the bench sweep every word and every one of the 64 byte addresses, and check the control address field through all 256 codes, which shows the upper address bits being masked. Expected words are built arithmetically in the bench from the little-endian lane rule and a modular pointer model.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;

  localparam int unsigned HOST_W  = 32;
  localparam int unsigned LANES   = HOST_W / 8;
  localparam int unsigned DIR_POS = 31;
  localparam int unsigned ADV_POS = 30;

  // Pointer step with wrap to zero after the last word
  function automatic logic [31:0] wrap_next(logic [31:0] idx, logic [31:0] words);
    return (idx + 32'd1 >= words) ? 32'd0 : idx + 32'd1;
  endfunction

  // Little-endian lane extraction
  function automatic logic [7:0] lane_get(logic [HOST_W-1:0] w, logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

  // Replace one byte lane of a word
  function automatic logic [HOST_W-1:0] lane_put(logic [HOST_W-1:0] w, logic [7:0] b,
                                                 logic [1:0] lane);
    logic [HOST_W-1:0] r;
    r = w;
    r[8*lane +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/bufwin_ctrl.sv
module bufwin_ctrl #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_dir_in,
  input  logic              ctl_adv_in,
  input  logic [WIDX_W-1:0] ctl_ptr_in,
  input  logic              data_acc,
  input  logic              data_wr,
  output logic              dir_q,
  output logic              adv_q,
  output logic [WIDX_W-1:0] ptr_q,
  output logic              host_store,
  output logic              step
);
  import bufwin_pkg::*;

  logic moves_data;
  logic [WIDX_W-1:0] ptr_inc;

  // Data moves only when the access direction matches the programmed direction
  assign host_store = data_acc & data_wr & dir_q;
  assign moves_data = host_store | (data_acc & ~data_wr & ~dir_q);
  assign step       = moves_data & adv_q;
  assign ptr_inc    = WIDX_W'(wrap_next(32'(ptr_q), 32'(WORDS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      adv_q <= 1'b0;
      ptr_q <= '0;
    end else if (ctl_wr) begin
      dir_q <= ctl_dir_in;
      adv_q <= ctl_adv_in;
      ptr_q <= ctl_ptr_in;
    end else if (step) begin
      ptr_q <= ptr_inc;
    end
  end

  // R1: registers clear while reset is held
  always @(negedge clk) begin
    if (!rst_n) p_reset_clear_r1 : assert (ptr_q == '0 && !dir_q && !adv_q);
  end

  // R3: drain read with auto-advance steps the pointer
  p_drain_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !data_wr && !dir_q && adv_q && !ctl_wr)
      |=> ptr_q == WIDX_W'(wrap_next(32'($past(ptr_q)), 32'(WORDS))));

  // R5: the last word is followed by word 0
  p_wrap_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctl_wr && ptr_q == WIDX_W'(WORDS-1)) |=> ptr_q == '0);

  // R6: a write in drain direction leaves the pointer
  p_drain_write_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && data_wr && !dir_q && !ctl_wr) |=> $stable(ptr_q));

  // R7: a read in fill direction leaves the pointer
  p_fill_read_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !data_wr && dir_q && !ctl_wr) |=> $stable(ptr_q));

endmodule

// File: rtl/bufwin_store.sv
module bufwin_store #(
  parameter int unsigned WORDS   = 128,
  parameter int unsigned WIDX_W  = $clog2(WORDS),
  parameter int unsigned BADDR_W = WIDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_busy,
  input  logic               h_we,
  input  logic [WIDX_W-1:0]  h_idx,
  input  logic [31:0]        h_wdata,
  output logic [31:0]        h_rword,
  input  logic               e_en,
  input  logic               e_we,
  input  logic [BADDR_W-1:0] e_baddr,
  input  logic [7:0]         e_wdata,
  output logic [7:0]         e_rdata
);
  import bufwin_pkg::*;

  logic [31:0] mem [WORDS];
  logic [WIDX_W-1:0] e_widx;
  logic [1:0]        e_lane;
  logic              e_fire;
  logic              e_drop;

  assign e_widx  = e_baddr[BADDR_W-1:2];
  assign e_lane  = e_baddr[1:0];
  assign e_drop  = e_en & e_we & h_busy;
  assign e_fire  = e_en & e_we & ~h_busy;
  assign h_rword = mem[h_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
    end else if (h_we) begin
      mem[h_idx] <= h_wdata;
    end else if (e_fire) begin
      mem[e_widx] <= lane_put(mem[e_widx], e_wdata, e_lane);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                e_rdata <= '0;
    else if (e_en && !e_we)    e_rdata <= lane_get(mem[e_widx], e_lane);
  end

  // R10: host word survives a same-cycle engine write
  p_host_wins_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && e_drop) |=> mem[$past(h_idx)] == $past(h_wdata));

  // R8/R9: an accepted engine byte lands in its little-endian lane
  p_lane_land_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    e_fire |=> lane_get(mem[$past(e_widx)], $past(e_lane)) == $past(e_wdata));

endmodule

// File: rtl/bufwin_top.sv
module bufwin_top #(
  parameter int unsigned WORDS   = 128,
  localparam int unsigned WIDX_W  = $clog2(WORDS),
  localparam int unsigned BADDR_W = WIDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_sel,
  input  logic               hst_wr,
  input  logic               hst_dsel,
  input  logic [31:0]        hst_wdata,
  output logic [31:0]        hst_rdata,
  input  logic               eng_en,
  input  logic               eng_we,
  input  logic [BADDR_W-1:0] eng_addr,
  input  logic [7:0]         eng_wdata,
  output logic [7:0]         eng_rdata
);
  import bufwin_pkg::*;

  logic              ctl_wr, data_acc;
  logic              dir_q, adv_q, host_store, step;
  logic [WIDX_W-1:0] ptr_q;
  logic [31:0]       h_rword, ctl_word;

  assign ctl_wr   = hst_sel & hst_wr & ~hst_dsel;
  assign data_acc = hst_sel & hst_dsel;
  assign ctl_word = {dir_q, adv_q, 22'd0, 8'(ptr_q)};

  bufwin_ctrl #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_dir_in (hst_wdata[DIR_POS]),
    .ctl_adv_in (hst_wdata[ADV_POS]),
    .ctl_ptr_in (hst_wdata[WIDX_W-1:0]),
    .data_acc   (data_acc),
    .data_wr    (hst_wr),
    .dir_q      (dir_q),
    .adv_q      (adv_q),
    .ptr_q      (ptr_q),
    .host_store (host_store),
    .step       (step)
  );

  bufwin_store #(.WORDS(WORDS), .WIDX_W(WIDX_W), .BADDR_W(BADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_busy  (data_acc),
    .h_we    (host_store),
    .h_idx   (ptr_q),
    .h_wdata (hst_wdata),
    .h_rword (h_rword),
    .e_en    (eng_en),
    .e_we    (eng_we),
    .e_baddr (eng_addr),
    .e_wdata (eng_wdata),
    .e_rdata (eng_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hst_rdata <= '0;
    else if (hst_sel && !hst_wr) hst_rdata <= hst_dsel ? h_rword : ctl_word;
  end

  // R4: a fill-direction write with auto-advance always steps the pointer
  p_fill_step_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && hst_wr && hst_dsel && dir_q && adv_q) |=> $changed(ptr_q) || WORDS == 1);

endmodule

// File: tb/test_bufwin_top.sv
module test_bufwin_top;
  localparam int unsigned NW = 16;
  localparam int unsigned NB = NW * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_sel = 0, hst_wr = 0, hst_dsel = 0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        eng_en = 0, eng_we = 0;
  logic [5:0]  eng_addr = '0;
  logic [7:0]  eng_wdata = '0;
  logic [7:0]  eng_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] exp_mem [NW];

  always #4 clk = ~clk;

  bufwin_top #(.WORDS(NW)) i_bufwin_top (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_dsel(hst_dsel),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .eng_en(eng_en), .eng_we(eng_we),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic dsel, input logic [31:0] d);
    @(negedge clk);
    hst_sel = 1; hst_wr = 1; hst_dsel = dsel; hst_wdata = d;
    @(negedge clk);
    hst_sel = 0; hst_wr = 0;
  endtask

  task automatic host_rd(input logic dsel, output logic [31:0] d);
    @(negedge clk);
    hst_sel = 1; hst_wr = 0; hst_dsel = dsel;
    @(negedge clk);
    hst_sel = 0;
    d = hst_rdata;
  endtask

  task automatic eng_wr(input int b, input logic [7:0] v);
    @(negedge clk);
    eng_en = 1; eng_we = 1; eng_addr = 6'(b); eng_wdata = v;
    @(negedge clk);
    eng_en = 0; eng_we = 0;
  endtask

  task automatic eng_rd(input int b, output logic [7:0] v);
    @(negedge clk);
    eng_en = 1; eng_we = 0; eng_addr = 6'(b);
    @(negedge clk);
    eng_en = 0;
    v = eng_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic d, input logic a, input int p);
    return {d, a, 22'd0, 8'(p % NW)};
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'(i) * 32'h01030507 ^ 32'hA55A3CC3;
  endfunction

  initial begin
    logic [31:0] rd;
    logic [7:0]  rb;
    for (int i = 0; i < int'(NW); i++) exp_mem[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", hst_rdata, 32'h0);
    rst_n = 1;
    host_rd(0, rd);
    chk("R1 control after reset", rd, 32'h0);

    // R2: control field sweep over all address codes
    for (int a = 0; a < 256; a++) begin
      logic d, v;
      d = a[0]; v = a[1];
      host_wr(0, {d, v, 22'h2AAAAA, 8'(a)});
      host_rd(0, rd);
      chk("R2 control readback", rd, ctl(d, v, a));
    end

    // R4/R5: streamed fill that wraps twice
    host_wr(0, ctl(1, 1, 0));
    for (int i = 0; i < 2 * int'(NW) + 3; i++) begin
      host_wr(1, pat(i));
      exp_mem[i % NW] = pat(i);
    end
    host_rd(0, rd);
    chk("R5 pointer after wrapped fill", rd, ctl(1, 1, 3));

    // R8: every engine byte against the little-endian rule
    for (int b = 0; b < int'(NB); b++) begin
      eng_rd(b, rb);
      chk("R8 engine byte lane", 32'(rb), 32'(exp_mem[b / 4][8 * (b % 4) +: 8]));
    end

    // R3: streamed drain from a middle start
    host_wr(0, ctl(0, 1, 5));
    for (int i = 0; i < 20; i++) begin
      host_rd(1, rd);
      chk("R3 drain word", rd, exp_mem[(5 + i) % NW]);
    end
    host_rd(0, rd);
    chk("R3 pointer after drain", rd, ctl(0, 1, 25));

    // R3: drain without auto-advance holds the pointer
    host_wr(0, ctl(0, 0, 9));
    for (int i = 0; i < 3; i++) begin
      host_rd(1, rd);
      chk("R3 no-advance repeat", rd, exp_mem[9]);
    end
    host_rd(0, rd);
    chk("R3 no-advance pointer", rd, ctl(0, 0, 9));

    // R6: write in drain direction ignored
    host_wr(0, ctl(0, 1, 2));
    host_wr(1, 32'hDEADBEEF);
    host_rd(0, rd);
    chk("R6 pointer unchanged", rd, ctl(0, 1, 2));
    host_rd(1, rd);
    chk("R6 buffer unchanged", rd, exp_mem[2]);

    // R7: read in fill direction returns current word, no step
    host_wr(0, ctl(1, 1, 7));
    host_rd(1, rd);
    chk("R7 fill-direction read", rd, exp_mem[7]);
    host_rd(0, rd);
    chk("R7 pointer unchanged", rd, ctl(1, 1, 7));

    // R9/R8: engine writes every byte, host drains whole words
    for (int b = 0; b < int'(NB); b++) begin
      eng_wr(b, 8'(b * 7 + 3));
      exp_mem[b / 4][8 * (b % 4) +: 8] = 8'(b * 7 + 3);
    end
    host_wr(0, ctl(0, 1, 0));
    for (int i = 0; i < int'(NW); i++) begin
      host_rd(1, rd);
      chk("R9 engine-built word", rd, exp_mem[i]);
    end

    // R9: a single byte write leaves its neighbours
    eng_wr(21, 8'h5C);
    exp_mem[5][15:8] = 8'h5C;
    eng_rd(20, rb);
    chk("R9 lower neighbour", 32'(rb), 32'(exp_mem[5][7:0]));
    eng_rd(22, rb);
    chk("R9 upper neighbour", 32'(rb), 32'(exp_mem[5][23:16]));
    eng_rd(21, rb);
    chk("R11 engine read value", 32'(rb), 32'h5C);

    // R10: host and engine hit the same word in one cycle
    host_wr(0, ctl(1, 0, 3));
    @(negedge clk);
    hst_sel = 1; hst_wr = 1; hst_dsel = 1; hst_wdata = 32'h11223344;
    eng_en = 1; eng_we = 1; eng_addr = 6'd12; eng_wdata = 8'hEE;
    @(negedge clk);
    hst_sel = 0; hst_wr = 0; eng_en = 0; eng_we = 0;
    exp_mem[3] = 32'h11223344;
    host_rd(1, rd);
    chk("R10 host wins same word", rd, exp_mem[3]);

    // R10: engine write to another word dropped during host access
    @(negedge clk);
    hst_sel = 1; hst_wr = 1; hst_dsel = 1; hst_wdata = 32'h0BADF00D;
    eng_en = 1; eng_we = 1; eng_addr = 6'd40; eng_wdata = 8'h99;
    @(negedge clk);
    hst_sel = 0; hst_wr = 0; eng_en = 0; eng_we = 0;
    exp_mem[3] = 32'h0BADF00D;
    eng_rd(40, rb);
    chk("R10 engine write dropped", 32'(rb), 32'(exp_mem[10][7:0]));

    // R11: engine read sees the byte held before a same-edge host write
    host_wr(0, ctl(1, 0, 4));
    @(negedge clk);
    hst_sel = 1; hst_wr = 1; hst_dsel = 1; hst_wdata = 32'hCAFE0042;
    eng_en = 1; eng_we = 0; eng_addr = 6'd16;
    @(negedge clk);
    hst_sel = 0; hst_wr = 0; eng_en = 0;
    chk("R11 read-before-write byte", 32'(eng_rdata), 32'(exp_mem[4][7:0]));
    exp_mem[4] = 32'hCAFE0042;
    eng_rd(16, rb);
    chk("R11 byte after host write", 32'(rb), 32'h42);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule